// File: doc/BRIEF.md
# Address-Match Bus Break Controller

This block is a two-channel debug breakpoint unit that watches a processor bus. On every bus cycle marked valid, each channel compares the bus address with its own programmed break address. A programmable number of low address bits can be left out of that compare. The cycle is also screened by its kind (instruction fetch, data read, data write) and by which master owns the bus: the CPU or the transfer controller. When everything agrees, the channel sets a sticky match flag. If the channel's interrupt is enabled, it then drives a level interrupt request.

Software reaches the block through a byte-wide register port. Each channel has one control byte and three break-address bytes. The match flag can only be cleared in one way: read it back as 1, then write 0 to it. This means a match can never be lost to a blind write.

Top module: `bus_break_unit`

## Requirements
- R1: After reset every register reads 0, and both interrupt outputs are 0.
- R2: The control bytes of channels A and B sit at register addresses 0 and 1. The break address of channel A is at addresses 4, 5 and 6, low byte first; channel B's is at 8, 9 and 10. Control bits 6..0 and all address bytes read back as written. Control bit 7 reads as the match flag and is never set by a write. Other addresses read 0 and ignore writes.
- R3: The control layout is: bit 7 = flag, bit 6 = master select, bits 5..3 = mask code, bits 2..1 = condition, bit 0 = interrupt enable. The mask code leaves the lowest N address bits out of the compare. Codes 0, 1, 2 and 3 give N = 0, 1, 2 and 3. Codes 4, 5, 6 and 7 give N = 4, 8, 12 and 16.
- R4: The bus kind is coded as 00 fetch, 01 read, 10 write and 11 idle. Condition 00 matches fetch only, 01 read only, 10 write only, and 11 either read or write. An idle cycle never matches.
- R5: The bus master input is 0 for the CPU and 1 for the transfer controller. With master select 0, only CPU cycles match. With master select 1, both masters match.
- R6: A qualified match with bus_valid high sets the flag. The flag is visible after that clock edge and stays set. Nothing matches while bus_valid is low.
- R7: A control write with bit 7 = 0 clears the flag only if the flag was read as 1 since the last control write. Every control write uses up that permission. A write with bit 7 = 1 leaves the flag unchanged.
- R8: If a match and a permitted clear happen in the same cycle, the flag ends up set.
- R9: A channel's interrupt is high exactly while its flag and its enable bit are both 1.
- R10: The two channels are independent: a match or a clear on one channel never changes the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register byte address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, 0 when not reading |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_addr | input | 24 | Monitored bus address |
| bus_kind | input | 2 | Cycle kind: 00 fetch, 01 read, 10 write, 11 idle |
| bus_master | input | 1 | 0 CPU, 1 transfer controller |
| irq | output | 2 | Level interrupt request, bit 0 channel A, bit 1 channel B |

## Verification
Every mask code is tested against a single-bit address difference at each of the 24 bit positions. An off-by-one or swapped entry in the ignored-width table would show up as a missed or extra match at exactly one boundary bit.

The full cross of condition, master select, cycle kind and master is swept. A design that lets idle cycles or transfer-controller cycles through would raise a flag that the expected value forbids.

The clear rules are tested in three ways:
- a write of 0 with no prior read, which must leave the flag set;
- a write of 1 followed by a write of 0, which must also leave it set, because the first write uses up the permission;
- a match in the same cycle as a permitted clear, which must leave the flag set.

A design that clears unconditionally, or lets the clear win, would drop the interrupt in one of these cases.

// File: rtl/bbu_pkg.sv
package bbu_pkg;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'b00,
    KIND_READ  = 2'b01,
    KIND_WRITE = 2'b10,
    KIND_IDLE  = 2'b11
  } bus_kind_e;

  typedef enum logic [1:0] {
    COND_FETCH = 2'b00,
    COND_READ  = 2'b01,
    COND_WRITE = 2'b10,
    COND_RDWR  = 2'b11
  } cond_sel_e;

  localparam logic MASTER_CPU = 1'b0;

  // Control byte: flag[7] any_master[6] mask_code[5:3] cond[2:1] ien[0]
  typedef struct packed {
    logic      flag;
    logic      any_master;
    logic [2:0] mask_code;
    cond_sel_e cond;
    logic      ien;
  } ctrl_t;

  // Number of low address bits left out of the compare.
  function automatic logic [5:0] ignored_low_bits(input logic [2:0] code);
    if (code[2]) return {2'b00, code[1:0], 2'b00} + 6'd4;
    else         return {3'b000, code};
  endfunction

endpackage

// File: rtl/bbu_addr_cmp.sv
module bbu_addr_cmp
  import bbu_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] brk_addr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [2:0]        mask_code,
  output logic              addr_hit
);

  logic [5:0]        ign_bits;
  logic [ADDR_W-1:0] care;

  assign ign_bits = ignored_low_bits(mask_code);

  for (genvar gi = 0; gi < ADDR_W; gi++) begin : g_care
    assign care[gi] = (gi >= int'(ign_bits));
  end

  assign addr_hit = (((brk_addr ^ bus_addr) & care) == '0);

endmodule

// File: rtl/bbu_cycle_qual.sv
module bbu_cycle_qual
  import bbu_pkg::*;
(
  input  logic      bus_valid,
  input  logic [1:0] bus_kind,
  input  logic      bus_master,
  input  cond_sel_e cond,
  input  logic      any_master,
  output logic      cyc_ok
);

  logic kind_ok;
  logic master_ok;

  always_comb begin
    unique case (cond)
      COND_FETCH: kind_ok = (bus_kind == KIND_FETCH);
      COND_READ:  kind_ok = (bus_kind == KIND_READ);
      COND_WRITE: kind_ok = (bus_kind == KIND_WRITE);
      default:    kind_ok = (bus_kind == KIND_READ) || (bus_kind == KIND_WRITE);
    endcase
  end

  assign master_ok = any_master || (bus_master == MASTER_CPU);
  assign cyc_ok    = bus_valid && kind_ok && master_ok;

endmodule

// File: rtl/bbu_channel.sv
module bbu_channel
  import bbu_pkg::*;
#(
  parameter  int ADDR_W = 24,
  localparam int NB     = (ADDR_W + 7) / 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctrl_wr,
  input  logic            ctrl_rd,
  input  logic [NB-1:0]   byte_wr,
  input  logic [7:0]      wdata,
  input  logic            bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]      bus_kind,
  input  logic            bus_master,
  output logic [7:0]      ctrl_byte,
  output logic [NB*8-1:0] addr_bytes,
  output logic            hit,
  output logic            armed,
  output logic            irq
);

  ctrl_t      ctrl_q, ctrl_d;
  logic       armed_q, armed_d;
  logic [7:0] byte_q [NB];
  logic [ADDR_W-1:0] brk_addr;
  logic       addr_hit;
  logic       cyc_ok;

  // Break address bytes, each with its own write enable
  for (genvar gb = 0; gb < NB; gb++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q[gb] <= '0;
      end else if (byte_wr[gb]) begin
        byte_q[gb] <= wdata;
      end
    end
    assign addr_bytes[gb*8 +: 8] = byte_q[gb];
  end

  assign brk_addr = addr_bytes[ADDR_W-1:0];

  bbu_addr_cmp #(.ADDR_W(ADDR_W)) cmp_i (
    .brk_addr  (brk_addr),
    .bus_addr  (bus_addr),
    .mask_code (ctrl_q.mask_code),
    .addr_hit  (addr_hit)
  );

  bbu_cycle_qual qual_i (
    .bus_valid  (bus_valid),
    .bus_kind   (bus_kind),
    .bus_master (bus_master),
    .cond       (ctrl_q.cond),
    .any_master (ctrl_q.any_master),
    .cyc_ok     (cyc_ok)
  );

  assign hit = cyc_ok && addr_hit;

  // Next state: a write uses up the clear permission; a match beats a clear
  always_comb begin
    ctrl_d  = ctrl_q;
    armed_d = armed_q;
    if (ctrl_wr) begin
      ctrl_d.any_master = wdata[6];
      ctrl_d.mask_code  = wdata[5:3];
      ctrl_d.cond       = cond_sel_e'(wdata[2:1]);
      ctrl_d.ien        = wdata[0];
      if (!wdata[7] && armed_q) ctrl_d.flag = 1'b0;
      armed_d = 1'b0;
    end else if (ctrl_rd && ctrl_q.flag) begin
      armed_d = 1'b1;
    end
    if (hit) ctrl_d.flag = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      armed_q <= armed_d;
    end
  end

  assign ctrl_byte = ctrl_q;
  assign armed     = armed_q;
  assign irq       = ctrl_q.flag && ctrl_q.ien;

endmodule

// File: rtl/bus_break_unit.sv
module bus_break_unit
  import bbu_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 24,
  parameter int REG_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_kind,
  input  logic              bus_master,
  output logic [NUM_CH-1:0] irq
);

  localparam int NB         = (ADDR_W + 7) / 8;
  localparam int WIN_STRIDE = 1 << $clog2(NB);
  localparam int CTRL_BASE  = 0;
  localparam int WIN_BASE   = WIN_STRIDE * ((NUM_CH + WIN_STRIDE - 1) / WIN_STRIDE);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic [NUM_CH-1:0]           ctrl_wr_v, ctrl_rd_v;
  logic [NUM_CH-1:0][NB-1:0]   byte_wr_v;
  logic [NUM_CH-1:0][7:0]      ctrl_byte_v;
  logic [NUM_CH-1:0][NB*8-1:0] addr_bytes_v;
  logic [NUM_CH-1:0]           hit_v, armed_v, flag_v, ien_v, clr_wr_v;

  // Address decode and read mux
  always_comb begin
    ctrl_wr_v = '0;
    ctrl_rd_v = '0;
    byte_wr_v = '0;
    reg_rdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (reg_addr == REG_AW'(CTRL_BASE + c)) begin
        ctrl_wr_v[c] = reg_wr;
        ctrl_rd_v[c] = reg_rd;
        if (reg_rd) reg_rdata = ctrl_byte_v[c];
      end
      for (int k = 0; k < NB; k++) begin
        if (reg_addr == REG_AW'(WIN_BASE + WIN_STRIDE * c + k)) begin
          byte_wr_v[c][k] = reg_wr;
          if (reg_rd) reg_rdata = addr_bytes_v[c][k*8 +: 8];
        end
      end
    end
  end

  for (genvar gc = 0; gc < NUM_CH; gc++) begin : g_ch
    bbu_channel #(.ADDR_W(ADDR_W)) ch_i (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .ctrl_wr    (ctrl_wr_v[gc]),
      .ctrl_rd    (ctrl_rd_v[gc]),
      .byte_wr    (byte_wr_v[gc]),
      .wdata      (reg_wdata),
      .bus_valid  (bus_valid),
      .bus_addr   (bus_addr),
      .bus_kind   (bus_kind),
      .bus_master (bus_master),
      .ctrl_byte  (ctrl_byte_v[gc]),
      .addr_bytes (addr_bytes_v[gc]),
      .hit        (hit_v[gc]),
      .armed      (armed_v[gc]),
      .irq        (irq[gc])
    );
    assign flag_v[gc]   = ctrl_byte_v[gc][7];
    assign ien_v[gc]    = ctrl_byte_v[gc][0];
    assign clr_wr_v[gc] = ctrl_wr_v[gc] && !reg_wdata[7];
  end

endmodule

// File: rtl/bbu_checker.sv
module bbu_checker #(
  parameter int NUM_CH = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] irq,
  input logic [NUM_CH-1:0] flag,
  input logic [NUM_CH-1:0] ien,
  input logic [NUM_CH-1:0] armed,
  input logic [NUM_CH-1:0] hit,
  input logic [NUM_CH-1:0] clr_wr
);

  for (genvar gc = 0; gc < NUM_CH; gc++) begin : g_chk
    assert_flag_on_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hit[gc] |=> flag[gc]);

    assert_flag_needs_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag[gc] && !hit[gc]) |=> !flag[gc]);

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[gc] && !(clr_wr[gc] && armed[gc])) |=> flag[gc]);

    assert_set_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[gc] && clr_wr[gc] && armed[gc]) |=> flag[gc]);

    assert_armed_only_flagged_R7: assert property (@(posedge clk) disable iff (!rst_n)
      armed[gc] |-> flag[gc]);

    assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !ien[gc] |-> !irq[gc]);

    assert_irq_from_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq[gc] |-> flag[gc]);
  end

endmodule

bind bus_break_unit bbu_checker #(.NUM_CH(NUM_CH)) chk_i (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .irq    (irq),
  .flag   (flag_v),
  .ien    (ien_v),
  .armed  (armed_v),
  .hit    (hit_v),
  .clr_wr (clr_wr_v)
);

// File: tb/bus_break_unit_tb_top.sv
module bus_break_unit_tb_top;

  logic        clk;
  logic        rst_n;
  logic [3:0]  reg_addr;
  logic        reg_wr, reg_rd;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic        bus_valid;
  logic [23:0] bus_addr;
  logic [1:0]  bus_kind;
  logic        bus_master;
  logic [1:0]  irq;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  bus_break_unit dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_kind(bus_kind),
    .bus_master(bus_master), .irq(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic bus(input logic [23:0] a, input logic [1:0] k,
                     input logic m, input logic v);
    @(negedge clk);
    bus_addr = a; bus_kind = k; bus_master = m; bus_valid = v;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic prog_addr(input int ch, input logic [23:0] a);
    for (int k = 0; k < 3; k++) wr(4'(4 + 4 * ch + k), a[k*8 +: 8]);
  endtask

  function automatic int ign_of(input int code);
    return (code < 4) ? code : 4 * (code - 3);
  endfunction

  initial begin
    logic [7:0] d;
    logic [23:0] base_a;
    logic [6:0] low_a;
    rst_n = 1'b0; reg_addr = '0; reg_wr = 0; reg_rd = 0; reg_wdata = '0;
    bus_valid = 0; bus_addr = '0; bus_kind = 2'b11; bus_master = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset values
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), d);
      chk("R1", $sformatf("reset read addr %0d", a), d, 0);
    end
    chk("R1", "reset irq", irq, 0);

    // R2: register map and readback
    prog_addr(0, 24'h332211);
    prog_addr(1, 24'h665544);
    wr(0, 8'hFF);
    wr(1, 8'hAA);
    wr(2, 8'hFF); wr(7, 8'hFF); wr(15, 8'hFF);
    rd(0, d);  chk("R2", "ctrl A readback, flag not writable", d, 8'h7F);
    rd(1, d);  chk("R2", "ctrl B readback", d, 8'h2A);
    for (int k = 0; k < 3; k++) begin
      rd(4'(4 + k), d); chk("R2", $sformatf("A byte %0d", k), d, 8'h11 * (k + 1));
      rd(4'(8 + k), d); chk("R2", $sformatf("B byte %0d", k), d, 8'h11 * (k + 4));
    end
    rd(2, d);  chk("R2", "unmapped 2", d, 0);
    rd(7, d);  chk("R2", "unmapped 7", d, 0);
    rd(15, d); chk("R2", "unmapped 15", d, 0);
    chk("R9", "irq with enable but no flag", irq, 0);

    // R3: mask sweep on channel A, fetch by CPU
    base_a = 24'hA5C396;
    prog_addr(0, base_a);
    prog_addr(1, 24'h000000);
    wr(1, 8'h00);
    for (int code = 0; code < 8; code++) begin
      low_a = {1'b0, 3'(code), 2'b00, 1'b0};
      wr(0, {1'b0, low_a});
      for (int b = -1; b < 24; b++) begin
        logic [23:0] ba;
        logic        exp;
        ba  = (b < 0) ? base_a : (base_a ^ (24'd1 << b));
        exp = (b < ign_of(code));
        bus(ba, 2'b00, 1'b0, 1'b1);
        rd(0, d);
        chk("R3", $sformatf("mask code %0d flip bit %0d", code, b), d[7], exp);
        wr(0, {1'b0, low_a});
      end
    end
    rd(1, d); chk("R10", "channel B untouched by A sweep", d[7], 0);

    // R4/R5: condition and master sweep on channel B
    prog_addr(1, 24'h123456);
    for (int cond = 0; cond < 4; cond++)
      for (int ms = 0; ms < 2; ms++)
        for (int kind = 0; kind < 4; kind++)
          for (int m = 0; m < 2; m++) begin
            logic kind_ok, exp;
            kind_ok = (cond == 3) ? (kind == 1 || kind == 2) : (kind == cond);
            exp = kind_ok && (ms == 1 || m == 0);
            wr(1, {1'b0, 1'(ms), 3'b000, 2'(cond), 1'b0});
            bus(24'h123456, 2'(kind), 1'(m), 1'b1);
            rd(1, d);
            chk((kind_ok ? "R5" : "R4"),
                $sformatf("cond %0d msel %0d kind %0d master %0d", cond, ms, kind, m),
                d[7], exp);
            wr(1, {1'b0, 1'(ms), 3'b000, 2'(cond), 1'b0});
          end
    rd(0, d); chk("R10", "channel A untouched by B sweep", d[7], 0);

    // R6: no match while bus_valid is low; sticky afterwards
    wr(0, 8'h00);
    bus(base_a, 2'b00, 1'b0, 1'b0);
    rd(0, d); chk("R6", "no match with valid low", d[7], 0);
    wr(0, 8'h01);
    bus(base_a, 2'b00, 1'b0, 1'b1);
    chk("R9", "irq A after match", irq, 2'b01);
    repeat (5) @(negedge clk);
    chk("R6", "flag sticky (irq held)", irq, 2'b01);

    // R7: clear rules, observed through irq
    wr(0, 8'h01);
    chk("R7", "write 0 without prior read keeps flag", irq, 2'b01);
    rd(0, d); chk("R7", "flag reads 1", d[7], 1);
    wr(0, 8'h81);
    chk("R7", "write 1 keeps flag", irq, 2'b01);
    wr(0, 8'h01);
    chk("R7", "permission used by previous write", irq, 2'b01);
    rd(0, d);
    wr(0, 8'h01);
    chk("R7", "read 1 then write 0 clears", irq, 2'b00);
    rd(0, d); chk("R7", "flag reads 0 after clear", d[7], 0);

    // R8: match and permitted clear in the same cycle
    bus(base_a, 2'b00, 1'b0, 1'b1);
    rd(0, d);
    @(negedge clk);
    reg_addr = 4'd0; reg_wdata = 8'h01; reg_wr = 1'b1;
    bus_addr = base_a; bus_kind = 2'b00; bus_master = 1'b0; bus_valid = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; bus_valid = 1'b0;
    chk("R8", "set wins over clear", irq, 2'b01);

    // R9: enable gating as a level
    wr(0, 8'h80);
    chk("R9", "enable off masks irq", irq, 2'b00);
    wr(0, 8'h81);
    chk("R9", "enable on raises irq", irq, 2'b01);
    repeat (4) @(negedge clk);
    chk("R9", "irq held as level", irq, 2'b01);
    rd(1, d); chk("R10", "channel B flag still clear", d[7], 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule